// File: doc/BRIEF.md
# Multi-Slope Run-Up Charge-Balance Controller

This block sequences the run-up phase of an integrating converter. The unknown input stays on the integrator for the entire run-up. The references only add or remove charge so that the integrator output stays inside its usable swing. The run-up is divided into decision periods of a fixed number of clock cycles. At each period boundary the controller samples a threshold comparator. It then drives either the positive or the negative reference enable for the next period. A reading above the threshold selects the positive reference, which pulls the integrator back down. A reading below the threshold selects the negative reference.

Two counters record how many periods used each reference. Together with their signed difference they form the coarse result of the conversion. The difference is reported with a one-cycle done pulse when the programmed number of periods has elapsed. A run-time balanced mode keeps the switching error roughly constant by turning each switch on exactly once in every period. The period's decision then only sets how long each switch stays on. Any offset that is left over is therefore fixed and can be removed downstream.

The analog integrator and comparator are outside this block. A host pulses start with a period count, waits for done, and reads the counts.

Top module: `runup_balancer`

## Requirements
- R1: After reset both reference enables are low, both counts and the difference are zero, and done is low.
- R2: A start pulse with a non-zero period count while idle begins a run at the next clock edge. The comparator value sampled at that edge decides period 0. Each period lasts PERIOD_CYC cycles, and each later period is decided by the comparator value at the edge that ends the previous period. The comparator is ignored at every other edge.
- R3: In normal mode (balanced input low at start), a decision of 1 (comparator above threshold) holds the positive enable high for the whole period, and a decision of 0 holds the negative enable high for the whole period.
- R4: During a run exactly one of the two enables is high in every cycle. Outside a run both are low.
- R5: The positive count rises by one at each edge that makes a decision of 1, and the negative count rises by one at each decision of 0. Both counts restart from the first decision of a new run, and their sum equals the number of periods decided so far.
- R6: Done is high for exactly one cycle, the cycle after the last period ends. Both enables are low in that cycle. The counts and the difference stay unchanged from then until the next accepted start.
- R7: The difference output equals the positive count minus the negative count, as a CNT_W+1 bit two's complement value.
- R8: In balanced mode every period drives the positive enable first and then the negative enable. A decision of 1 gives the positive enable PERIOD_CYC-1 cycles and the negative enable 1 cycle. A decision of 0 gives the positive enable 1 cycle and the negative enable PERIOD_CYC-1 cycles. Each enable therefore rises exactly once per period.
- R9: A start that arrives while a run is in progress is ignored. So is a start with a period count of zero: no run begins, no done pulse follows, and the counts are unchanged.
- R10: A start in the done cycle is accepted. The new run's first period begins in the next cycle with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run-up (single-cycle pulse) |
| n_periods_i | input | CNT_W | Number of decision periods in the run, sampled with start |
| balanced_i | input | 1 | Balanced switching mode, sampled with start |
| cmp_above_i | input | 1 | Comparator: 1 when the integrator is above the threshold |
| ref_pos_o | output | 1 | Positive reference switch enable |
| ref_neg_o | output | 1 | Negative reference switch enable |
| pos_count_o | output | CNT_W | Periods decided for the positive reference |
| neg_count_o | output | CNT_W | Periods decided for the negative reference |
| diff_o | output | CNT_W+1 | Signed positive minus negative count |
| done_o | output | 1 | One-cycle pulse after the last period |

## Verification
The two functions that can meet in one cycle are the end-of-run report and the acceptance of the next start. The bench raises start in the very cycle that done is high. At the next sample it expects done to be gone, the new run's first enable to be driving, and the counts to have restarted from the new first decision. In the done cycle itself it expects the previous run's totals. A second collision is forced by raising start with a different count in the middle of a run, including at the final boundary edge. In that case the run must end on its original period count.

// File: rtl/rub_pkg.sv
package rub_pkg;

  // Reference selected for a decision period
  typedef enum logic {
    SEL_NEG = 1'b0,
    SEL_POS = 1'b1
  } ref_sel_e;

  localparam int NUM_REFS = 2;

endpackage

// File: rtl/rub_sequencer.sv
module rub_sequencer #(
  parameter int CNT_W      = 20,
  parameter int PERIOD_CYC = 4,
  localparam int SLOT_W    = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  n_periods_i,
  input  logic              balanced_i,
  input  logic              cmp_above_i,
  output logic              run_o,
  output logic [SLOT_W-1:0] slot_o,
  output rub_pkg::ref_sel_e choice_o,
  output logic              bal_o,
  output logic              decide_o,
  output logic              first_o,
  output logic              done_o
);
  import rub_pkg::*;

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PERIOD_CYC - 1);

  logic              run_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  left_q;
  ref_sel_e          choice_q;
  logic              bal_q;
  logic              done_q;

  logic accept, boundary, finish, renew;

  always_comb begin
    accept   = !run_q && start_i && (n_periods_i != '0);
    boundary = run_q && (slot_q == LAST_SLOT);
    finish   = boundary && (left_q == '0);
    renew    = boundary && !finish;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      slot_q   <= '0;
      left_q   <= '0;
      choice_q <= SEL_NEG;
      bal_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        run_q    <= 1'b1;
        slot_q   <= '0;
        left_q   <= n_periods_i - CNT_W'(1);
        choice_q <= ref_sel_e'(cmp_above_i);
        bal_q    <= balanced_i;
      end else if (run_q) begin
        if (boundary) begin
          slot_q <= '0;
          if (finish) begin
            run_q <= 1'b0;
          end else begin
            left_q   <= left_q - CNT_W'(1);
            choice_q <= ref_sel_e'(cmp_above_i);
          end
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end
    end
  end

  assign run_o    = run_q;
  assign slot_o   = slot_q;
  assign choice_o = choice_q;
  assign bal_o    = bal_q;
  assign decide_o = accept || renew;
  assign first_o  = accept;
  assign done_o   = done_q;

endmodule

// File: rtl/rub_tally.sv
module rub_tally #(
  parameter int CNT_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    decide_i,
  input  logic                    first_i,
  input  logic                    pick_i,
  output logic [CNT_W-1:0]        pos_count_o,
  output logic [CNT_W-1:0]        neg_count_o,
  output logic signed [CNT_W:0]   diff_o
);
  import rub_pkg::*;

  logic [CNT_W-1:0] cnt_q [NUM_REFS];

  // Index 0 counts negative decisions, index 1 positive ones
  for (genvar g = 0; g < NUM_REFS; g++) begin : g_ctr
    logic hit;
    assign hit = (pick_i == (g == 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
      end else if (decide_i) begin
        if (first_i) cnt_q[g] <= CNT_W'(hit);
        else         cnt_q[g] <= cnt_q[g] + CNT_W'(hit);
      end
    end
  end

  assign pos_count_o = cnt_q[1];
  assign neg_count_o = cnt_q[0];
  assign diff_o      = $signed({1'b0, cnt_q[1]}) - $signed({1'b0, cnt_q[0]});

endmodule

// File: rtl/rub_switch_drive.sv
module rub_switch_drive #(
  parameter int PERIOD_CYC = 4,
  localparam int SLOT_W    = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1
) (
  input  logic              run_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  rub_pkg::ref_sel_e choice_i,
  input  logic              bal_i,
  output logic              ref_pos_o,
  output logic              ref_neg_o
);
  import rub_pkg::*;

  localparam logic [SLOT_W:0] LONG_LEN  = (SLOT_W + 1)'(PERIOD_CYC - 1);
  localparam logic [SLOT_W:0] SHORT_LEN = (SLOT_W + 1)'(1);

  logic [SLOT_W:0] pos_len;
  logic            pos_phase;

  always_comb begin
    pos_len   = (choice_i == SEL_POS) ? LONG_LEN : SHORT_LEN;
    pos_phase = bal_i ? ({1'b0, slot_i} < pos_len) : (choice_i == SEL_POS);
    ref_pos_o = run_i && pos_phase;
    ref_neg_o = run_i && !pos_phase;
  end

endmodule

// File: rtl/runup_balancer.sv
module runup_balancer #(
  parameter int CNT_W      = 20,
  parameter int PERIOD_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      n_periods_i,
  input  logic                  balanced_i,
  input  logic                  cmp_above_i,
  output logic                  ref_pos_o,
  output logic                  ref_neg_o,
  output logic [CNT_W-1:0]      pos_count_o,
  output logic [CNT_W-1:0]      neg_count_o,
  output logic signed [CNT_W:0] diff_o,
  output logic                  done_o
);
  import rub_pkg::*;

  localparam int SLOT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;

  logic              run;
  logic [SLOT_W-1:0] slot;
  ref_sel_e          choice;
  logic              bal;
  logic              decide;
  logic              first;

  rub_sequencer #(.CNT_W(CNT_W), .PERIOD_CYC(PERIOD_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .n_periods_i (n_periods_i),
    .balanced_i  (balanced_i),
    .cmp_above_i (cmp_above_i),
    .run_o       (run),
    .slot_o      (slot),
    .choice_o    (choice),
    .bal_o       (bal),
    .decide_o    (decide),
    .first_o     (first),
    .done_o      (done_o)
  );

  rub_tally #(.CNT_W(CNT_W)) u_tally (
    .clk         (clk),
    .rst_n       (rst_n),
    .decide_i    (decide),
    .first_i     (first),
    .pick_i      (cmp_above_i),
    .pos_count_o (pos_count_o),
    .neg_count_o (neg_count_o),
    .diff_o      (diff_o)
  );

  rub_switch_drive #(.PERIOD_CYC(PERIOD_CYC)) u_drive (
    .run_i     (run),
    .slot_i    (slot),
    .choice_i  (choice),
    .bal_i     (bal),
    .ref_pos_o (ref_pos_o),
    .ref_neg_o (ref_neg_o)
  );

endmodule

// File: rtl/runup_balancer_checker.sv
module runup_balancer_checker #(
  parameter int CNT_W      = 20,
  parameter int PERIOD_CYC = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic [CNT_W-1:0]      n_periods_i,
  input logic                  ref_pos_o,
  input logic                  ref_neg_o,
  input logic [CNT_W-1:0]      pos_count_o,
  input logic [CNT_W-1:0]      neg_count_o,
  input logic                  done_o
);
  logic             active;
  logic [CNT_W-1:0] n_seen;

  assign active = ref_pos_o || ref_neg_o;

  // Outside a run the enables are low, so a start seen then is an accepted one
  always_ff @(posedge clk) begin
    if (!rst_n)                                    n_seen <= '0;
    else if (start_i && !active && n_periods_i != '0) n_seen <= n_periods_i;
  end

  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_pos_o && ref_neg_o));

  a_r4_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && !active) |-> done_o);

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active);

  a_r5_total_periods: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (({1'b0, pos_count_o} + {1'b0, neg_count_o}) == {1'b0, n_seen}));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(start_i)) |-> ($stable(pos_count_o) && $stable(neg_count_o)));

endmodule

bind runup_balancer runup_balancer_checker #(.CNT_W(CNT_W), .PERIOD_CYC(PERIOD_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .n_periods_i (n_periods_i),
  .ref_pos_o   (ref_pos_o),
  .ref_neg_o   (ref_neg_o),
  .pos_count_o (pos_count_o),
  .neg_count_o (neg_count_o),
  .done_o      (done_o)
);

// File: tb/tb_runup_balancer.sv
`timescale 1ns/1ps
module tb_runup_balancer;
  localparam int CNT_W = 20;
  localparam int PC    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [CNT_W-1:0] n_periods_i;
  logic balanced_i;
  logic cmp_above_i;
  logic ref_pos_o, ref_neg_o, done_o;
  logic [CNT_W-1:0] pos_count_o, neg_count_o;
  logic signed [CNT_W:0] diff_o;

  always #2.5 clk = ~clk;

  runup_balancer #(.CNT_W(CNT_W), .PERIOD_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_periods_i(n_periods_i),
    .balanced_i(balanced_i), .cmp_above_i(cmp_above_i),
    .ref_pos_o(ref_pos_o), .ref_neg_o(ref_neg_o),
    .pos_count_o(pos_count_o), .neg_count_o(neg_count_o),
    .diff_o(diff_o), .done_o(done_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit pat [0:255];
  int exp_pos = 0;
  int exp_neg = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected enable level of the positive switch in a given slot
  function automatic bit exp_pos_en(input bit bal, input bit ch, input int s);
    if (!bal) return ch;
    return s < (ch ? PC - 1 : 1);
  endfunction

  task automatic chk_counts(input string req);
    chk(pos_count_o == CNT_W'(exp_pos), req, "pos_count", pos_count_o, exp_pos);
    chk(neg_count_o == CNT_W'(exp_neg), req, "neg_count", neg_count_o, exp_neg);
    chk(int'(diff_o) == exp_pos - exp_neg, "R7", "diff", int'(diff_o), exp_pos - exp_neg);
  endtask

  // Entered right after a negedge; returns at the negedge of the done cycle
  task automatic run_one(input int n, input bit bal, input int poke, input bit chained);
    int rp = 0;
    int rn = 0;
    bit pp = 0;
    bit pn = 0;
    start_i = 1'b1; n_periods_i = CNT_W'(n); balanced_i = bal; cmp_above_i = pat[0];
    exp_pos = 0; exp_neg = 0;
    for (int p = 0; p < n; p++) begin
      bit ch = pat[p];
      if (ch) exp_pos++; else exp_neg++;
      for (int s = 0; s < PC; s++) begin
        bit ep;
        @(negedge clk);
        start_i = 1'b0;
        balanced_i = $urandom_range(0, 1);
        ep = exp_pos_en(bal, ch, s);
        chk(ref_pos_o == ep, (p == 0 && s == 0) ? (chained ? "R10" : "R2") : (bal ? "R8" : "R3"),
            "ref_pos", ref_pos_o, ep);
        chk(ref_neg_o == !ep, "R4", "ref_neg", ref_neg_o, !ep);
        chk(done_o == 1'b0, "R6", "done during run", done_o, 0);
        chk_counts((p == 0 && s == 0 && chained) ? "R10" : "R5");
        if (ref_pos_o && !pp) rp++;
        if (ref_neg_o && !pn) rn++;
        pp = ref_pos_o; pn = ref_neg_o;
        if (s == PC - 1) cmp_above_i = (p + 1 < n) ? pat[p + 1] : 1'($urandom);
        else             cmp_above_i = 1'($urandom);
        if (p * PC + s == poke) begin
          start_i = 1'b1;                 // R9: must be ignored mid-run
          n_periods_i = CNT_W'($urandom_range(1, 3));
        end
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R6", "done pulse", done_o, 1);
    chk(!ref_pos_o && !ref_neg_o, "R4", "enables in done cycle", {ref_pos_o, ref_neg_o}, 0);
    chk_counts(poke >= 0 ? "R9" : "R6");
    if (bal) begin
      chk(rp == n, "R8", "positive rises", rp, n);
      chk(rn == n, "R8", "negative rises", rn, n);
    end
  endtask

  task automatic idle_check(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      cmp_above_i = 1'($urandom);
      chk(done_o == 1'b0, req, "done while idle", done_o, 0);
      chk(!ref_pos_o && !ref_neg_o, "R4", "enables while idle", {ref_pos_o, ref_neg_o}, 0);
      chk_counts(req);
    end
  endtask

  task automatic fill(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      case (kind)
        1:       pat[i] = 1'b1;
        2:       pat[i] = 1'b0;
        3:       pat[i] = i[0];
        default: pat[i] = 1'($urandom);
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; n_periods_i = '0; balanced_i = 1'b0; cmp_above_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!ref_pos_o && !ref_neg_o, "R1", "enables after reset", {ref_pos_o, ref_neg_o}, 0);
    chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    chk(pos_count_o == '0 && neg_count_o == '0, "R1", "counts after reset",
        pos_count_o + neg_count_o, 0);
    chk(diff_o == '0, "R1", "diff after reset", diff_o, 0);

    // R9: zero period count is ignored
    start_i = 1'b1; n_periods_i = '0; cmp_above_i = 1'b1;
    idle_check(4, "R9");

    fill(1, 5);  run_one(5, 1'b0, -1, 1'b0);  idle_check(2, "R6");
    fill(2, 5);  run_one(5, 1'b0, -1, 1'b0);  idle_check(2, "R6");
    fill(0, 1);  run_one(1, 1'b0, -1, 1'b0);  idle_check(1, "R6");
    fill(1, 6);  run_one(6, 1'b1, -1, 1'b0);  idle_check(1, "R6");
    fill(3, 7);  run_one(7, 1'b1, -1, 1'b0);  idle_check(1, "R6");
    fill(0, 10); run_one(10, 1'b0, 13, 1'b0); idle_check(1, "R9");
    fill(0, 4);  run_one(4, 1'b1, 4 * PC - 1, 1'b0); idle_check(1, "R9");
    // R10: start in the done cycle
    fill(0, 8);  run_one(8, 1'b0, -1, 1'b0);
    fill(0, 3);  run_one(3, 1'b1, -1, 1'b1);  idle_check(1, "R6");

    for (int k = 0; k < 14; k++) begin
      int n = $urandom_range(1, 40);
      fill(0, n);
      run_one(n, 1'($urandom), ($urandom_range(0, 2) == 0) ? $urandom_range(0, n * PC - 1) : -1,
              1'b0);
      idle_check($urandom_range(1, 3), "R6");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule